// File: doc/BRIEF.md
# Interrupt and Bus-Request Arbiter

This block chooses what an 8-bit CPU core does next when its sequencer reaches a boundary. Three kinds of request compete. An external bus master asks for the bus with an active-low request, and the request is honoured when a machine cycle ends. A non-maskable interrupt is caught on a falling edge and held until an instruction ends. A maskable interrupt is an active-low level that is honoured only while the interrupt-enable flip-flop is set. A bus grant pulls the acknowledge output low and raises a float enable, which the pad logic uses to put the address, data and strobe lines into high impedance.

When an interrupt is accepted, the block emits a one-cycle service pulse. The pulse carries either a 16-bit target address or a flag that tells the core to run the opcode byte that the interrupting device placed on the bus. The maskable interrupt has three vectoring modes. Mode 0 runs a byte from the bus. Mode 1 uses a fixed address. Mode 2 forms the address from a page register (high byte) and the bus byte (low byte). The core sets the mode, loads the page register and enables, disables or restores the enable flip-flop through single-cycle command strobes. Reset is asynchronous and active low. The surrounding system holds it for at least three clocks.

Top module: `irq_bus_arbiter`

## Requirements
- R1: While reset is asserted, and after it is released, busAckN reads 1, floatEn reads 0 and svcValid reads 0. The enable flip-flop is cleared, the mode is 0 and the page register is 0x00.
- R2: When busReqN is low in a cycle with cycleEnd high, busAckN goes low and floatEn goes high one clock later. A request alone, with no cycleEnd, grants nothing. A grant persists while busReqN stays low.
- R3: While granted, busReqN high releases the bus one clock later: busAckN returns to 1 and floatEn to 0.
- R4: No interrupt is serviced while the bus is granted, or in a cycle where a bus grant is taken. Pending requests are serviced at a later instrEnd after release.
- R5: A falling edge on nmiN is latched. It is serviced at the next instrEnd whatever the enable state, with svcAddr 0x0066 and svcFromBus 0. The latch clears on service, and a level held low does not retrigger.
- R6: A pending non-maskable interrupt outranks a maskable one at the same boundary.
- R7: A low intN is serviced at instrEnd only while the enable flip-flop is set. Servicing clears the enable flip-flop and its shadow copy.
- R8: In mode 1 (cmdMode encoding 1) a maskable service gives svcAddr 0x0038 and svcFromBus 0.
- R9: In mode 0 (encoding 0) a maskable service gives svcFromBus 1, svcAddr 0x0000 and svcByte equal to ackByte.
- R10: In mode 2 (encoding 2) a maskable service gives svcAddr {page register, ackByte} and svcFromBus 0. cmdVecLoad loads the page register from cmdVecData.
- R11: cmdModeSet with cmdMode 0, 1 or 2 selects that mode. A write of 3 is ignored and leaves the previous mode in place.
- R12: Non-maskable service copies the enable flip-flop into the shadow and then clears the enable flip-flop. cmdRestore copies the shadow back. cmdEnable sets both, and cmdDisable clears both, winning over cmdEnable. A service in the same cycle overrides all of these commands.
- R13: svcValid is a one-cycle pulse one clock after the accepting instrEnd cycle. svcAddr, svcFromBus and svcByte are valid while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cycleEnd | input | 1 | Strobe marking the last clock of a machine cycle |
| instrEnd | input | 1 | Strobe marking the last clock of an instruction |
| busReqN | input | 1 | External bus request, active low |
| nmiN | input | 1 | Non-maskable interrupt, falling-edge triggered |
| intN | input | 1 | Maskable interrupt, active-low level |
| cmdEnable | input | 1 | Set the enable flip-flop and its shadow |
| cmdDisable | input | 1 | Clear the enable flip-flop and its shadow |
| cmdRestore | input | 1 | Copy the shadow back into the enable flip-flop |
| cmdModeSet | input | 1 | Write cmdMode into the mode register |
| cmdMode | input | 2 | Mode value: 0, 1 or 2 |
| cmdVecLoad | input | 1 | Load the page register from cmdVecData |
| cmdVecData | input | 8 | New page register value |
| ackByte | input | 8 | Byte supplied by the device during acknowledge |
| busAckN | output | 1 | Bus acknowledge, active low |
| floatEn | output | 1 | High while the core's bus lines must float |
| svcValid | output | 1 | One-cycle service pulse |
| svcFromBus | output | 1 | Service runs the opcode in svcByte instead of jumping |
| svcAddr | output | 16 | Service target address |
| svcByte | output | 8 | Byte captured from ackByte at acceptance |

## Verification
If the edge latch were stuck, an interrupt would be lost or serviced twice, and the stray or missing svcValid pulse appears one clock after the next instrEnd. A wrong enable or shadow flip-flop shows up at the next instrEnd with intN low, where a pulse is missing or an extra one appears. For that reason every test of the enable state is followed at once by such a boundary. A corrupt mode or page register shows in svcAddr or svcFromBus on the very next maskable service. The bench sweeps every mode write, including the illegal one, against a range of page and bus bytes to expose it. A grant-state fault shows at busAckN one clock after the request edge or the release edge.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    IM_OPCODE = 2'd0,
    IM_FIXED  = 2'd1,
    IM_PAGED  = 2'd2
  } intMode_t;

  typedef struct packed {
    logic takeNmi;
    logic takeInt;
    logic grantSet;
    logic grantClr;
  } arbStrobes_t;

endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
(
  input  logic        cycleEnd,
  input  logic        instrEnd,
  input  logic        busReqN,
  input  logic        intN,
  input  logic        nmiPend,
  input  logic        iffMain,
  input  logic        granted,
  output arbStrobes_t strb
);

  logic grabBus;
  logic canSvc;

  always_comb begin
    grabBus       = cycleEnd && !busReqN && !granted;
    canSvc        = instrEnd && !granted && !grabBus;
    strb.grantSet = grabBus;
    strb.grantClr = granted && busReqN;
    strb.takeNmi  = canSvc && nmiPend;
    strb.takeInt  = canSvc && !nmiPend && !intN && iffMain;
  end

endmodule

// File: rtl/arb_dp.sv
module arb_dp
  import arb_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int NMI_TARGET   = 'h66,
  parameter int FIXED_TARGET = 'h38,
  localparam int ADDR_W      = 2 * DATA_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  arbStrobes_t       strb,
  input  logic              nmiN,
  input  logic              cmdEnable,
  input  logic              cmdDisable,
  input  logic              cmdRestore,
  input  logic              cmdModeSet,
  input  logic [1:0]        cmdMode,
  input  logic              cmdVecLoad,
  input  logic [DATA_W-1:0] cmdVecData,
  input  logic [DATA_W-1:0] ackByte,
  output logic              nmiPend,
  output logic              iffMain,
  output logic              granted,
  output logic              svcValid,
  output logic              svcFromBus,
  output logic [ADDR_W-1:0] svcAddr,
  output logic [DATA_W-1:0] svcByte
);

  logic              nmiPrev;
  logic              iffSave;
  intMode_t          modeReg;
  logic [DATA_W-1:0] vecReg;
  logic [ADDR_W-1:0] nextAddr;
  logic              nextFromBus;

  always_comb begin
    nextFromBus = 1'b0;
    nextAddr    = '0;
    if (strb.takeNmi) begin
      nextAddr = ADDR_W'(NMI_TARGET);
    end else begin
      unique case (modeReg)
        IM_FIXED: nextAddr = ADDR_W'(FIXED_TARGET);
        IM_PAGED: nextAddr = {vecReg, ackByte};
        default:  nextFromBus = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiPrev    <= 1'b1;
      nmiPend    <= 1'b0;
      iffMain    <= 1'b0;
      iffSave    <= 1'b0;
      modeReg    <= IM_OPCODE;
      vecReg     <= '0;
      granted    <= 1'b0;
      svcValid   <= 1'b0;
      svcFromBus <= 1'b0;
      svcAddr    <= '0;
      svcByte    <= '0;
    end else begin
      nmiPrev <= nmiN;
      nmiPend <= (nmiPend && !strb.takeNmi) || (nmiPrev && !nmiN);

      if (strb.grantSet)      granted <= 1'b1;
      else if (strb.grantClr) granted <= 1'b0;

      if (strb.takeNmi) begin
        iffSave <= iffMain;
        iffMain <= 1'b0;
      end else if (strb.takeInt || cmdDisable) begin
        iffMain <= 1'b0;
        iffSave <= 1'b0;
      end else if (cmdEnable) begin
        iffMain <= 1'b1;
        iffSave <= 1'b1;
      end else if (cmdRestore) begin
        iffMain <= iffSave;
      end

      if (cmdModeSet && cmdMode != 2'd3) modeReg <= intMode_t'(cmdMode);
      if (cmdVecLoad) vecReg <= cmdVecData;

      svcValid <= strb.takeNmi || strb.takeInt;
      if (strb.takeNmi || strb.takeInt) begin
        svcFromBus <= nextFromBus;
        svcAddr    <= nextAddr;
        svcByte    <= ackByte;
      end
    end
  end

endmodule

// File: rtl/irq_bus_arbiter.sv
module irq_bus_arbiter
  import arb_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int NMI_TARGET   = 'h66,
  parameter int FIXED_TARGET = 'h38,
  localparam int ADDR_W      = 2 * DATA_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycleEnd,
  input  logic              instrEnd,
  input  logic              busReqN,
  input  logic              nmiN,
  input  logic              intN,
  input  logic              cmdEnable,
  input  logic              cmdDisable,
  input  logic              cmdRestore,
  input  logic              cmdModeSet,
  input  logic [1:0]        cmdMode,
  input  logic              cmdVecLoad,
  input  logic [DATA_W-1:0] cmdVecData,
  input  logic [DATA_W-1:0] ackByte,
  output logic              busAckN,
  output logic              floatEn,
  output logic              svcValid,
  output logic              svcFromBus,
  output logic [ADDR_W-1:0] svcAddr,
  output logic [DATA_W-1:0] svcByte
);

  arbStrobes_t strb;
  logic        nmiPend;
  logic        iffMain;
  logic        granted;

  arb_ctrl u_ctrl (
    .cycleEnd (cycleEnd),
    .instrEnd (instrEnd),
    .busReqN  (busReqN),
    .intN     (intN),
    .nmiPend  (nmiPend),
    .iffMain  (iffMain),
    .granted  (granted),
    .strb     (strb)
  );

  arb_dp #(
    .DATA_W       (DATA_W),
    .NMI_TARGET   (NMI_TARGET),
    .FIXED_TARGET (FIXED_TARGET)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .nmiN       (nmiN),
    .cmdEnable  (cmdEnable),
    .cmdDisable (cmdDisable),
    .cmdRestore (cmdRestore),
    .cmdModeSet (cmdModeSet),
    .cmdMode    (cmdMode),
    .cmdVecLoad (cmdVecLoad),
    .cmdVecData (cmdVecData),
    .ackByte    (ackByte),
    .nmiPend    (nmiPend),
    .iffMain    (iffMain),
    .granted    (granted),
    .svcValid   (svcValid),
    .svcFromBus (svcFromBus),
    .svcAddr    (svcAddr),
    .svcByte    (svcByte)
  );

  assign busAckN = !granted;
  assign floatEn = granted;

endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
)(
  input logic              clk,
  input logic              rstN,
  input logic              cycleEnd,
  input logic              instrEnd,
  input logic              busReqN,
  input logic              busAckN,
  input logic              svcValid,
  input logic              svcFromBus,
  input logic [ADDR_W-1:0] svcAddr
);

  p_grant_needs_boundary_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busAckN) |-> ($past(cycleEnd) && !$past(busReqN)));

  p_grant_holds_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busAckN && !busReqN) |=> !busAckN);

  p_release_next_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!busAckN && busReqN) |=> busAckN);

  p_no_svc_in_grant_r4: assert property (@(posedge clk) disable iff (!rstN)
    svcValid |-> busAckN);

  p_frombus_zero_addr_r9: assert property (@(posedge clk) disable iff (!rstN)
    (svcValid && svcFromBus) |-> (svcAddr == '0));

  p_svc_after_boundary_r13: assert property (@(posedge clk) disable iff (!rstN)
    svcValid |-> $past(instrEnd));

endmodule

bind irq_bus_arbiter arb_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cycleEnd   (cycleEnd),
  .instrEnd   (instrEnd),
  .busReqN    (busReqN),
  .busAckN    (busAckN),
  .svcValid   (svcValid),
  .svcFromBus (svcFromBus),
  .svcAddr    (svcAddr)
);

// File: tb/tb_irq_bus_arbiter.sv
`timescale 1ns/1ps
module tb_irq_bus_arbiter;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cycleEnd = 1'b0, instrEnd = 1'b0, busReqN = 1'b1, nmiN = 1'b1, intN = 1'b1;
  logic cmdEnable = 1'b0, cmdDisable = 1'b0, cmdRestore = 1'b0, cmdModeSet = 1'b0, cmdVecLoad = 1'b0;
  logic [1:0]  cmdMode = 2'd0;
  logic [7:0]  cmdVecData = 8'h00, ackByte = 8'h00;
  logic        busAckN, floatEn, svcValid, svcFromBus;
  logic [15:0] svcAddr;
  logic [7:0]  svcByte;

  int nChk = 0;
  int nErr = 0;

  always #10 clk = ~clk;

  irq_bus_arbiter dut (
    .clk(clk), .rstN(rstN), .cycleEnd(cycleEnd), .instrEnd(instrEnd),
    .busReqN(busReqN), .nmiN(nmiN), .intN(intN),
    .cmdEnable(cmdEnable), .cmdDisable(cmdDisable), .cmdRestore(cmdRestore),
    .cmdModeSet(cmdModeSet), .cmdMode(cmdMode), .cmdVecLoad(cmdVecLoad),
    .cmdVecData(cmdVecData), .ackByte(ackByte),
    .busAckN(busAckN), .floatEn(floatEn), .svcValid(svcValid),
    .svcFromBus(svcFromBus), .svcAddr(svcAddr), .svcByte(svcByte)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic endInstr();
    instrEnd = 1'b1;
    tick();
    instrEnd = 1'b0;
  endtask

  task automatic doEnable();
    cmdEnable = 1'b1; tick(); cmdEnable = 1'b0;
  endtask

  task automatic setMode(input logic [1:0] m);
    cmdModeSet = 1'b1; cmdMode = m; tick(); cmdModeSet = 1'b0;
  endtask

  task automatic nmiEdge();
    nmiN = 1'b0; tick(); tick(); nmiN = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nErr++;
    nChk++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

  initial begin
    logic [15:0] expAddr;
    logic [1:0]  effMode;
    tick(); tick();
    chk(busAckN == 1'b1 && floatEn == 1'b0 && svcValid == 1'b0, "R1 in reset", {busAckN, floatEn, svcValid}, 3'b100);
    tick(); tick();
    rstN = 1'b1;
    tick();
    chk(busAckN == 1'b1 && floatEn == 1'b0 && svcValid == 1'b0, "R1 after reset", {busAckN, floatEn, svcValid}, 3'b100);

    // R1 / R7: enable clear after reset, so a low intN is ignored
    intN = 1'b0; endInstr();
    chk(svcValid == 1'b0, "R1 R7 iff cleared by reset", svcValid, 0);
    // R1 / R9: mode 0 after reset
    doEnable(); ackByte = 8'hC7; endInstr(); intN = 1'b1;
    chk(svcValid && svcFromBus && svcByte == 8'hC7 && svcAddr == 16'h0, "R1 R9 reset mode 0",
        {svcValid, svcFromBus, svcAddr, svcByte}, {2'b11, 16'h0, 8'hC7});
    tick();
    chk(svcValid == 1'b0, "R13 single pulse", svcValid, 0);
    // R1 / R10: page register reset to 0
    setMode(2'd2); doEnable(); ackByte = 8'h5A; intN = 1'b0; endInstr(); intN = 1'b1;
    chk(svcValid && !svcFromBus && svcAddr == 16'h005A, "R1 R10 page reset", svcAddr, 16'h005A);

    // R8 R9 R10 R11 sweep over mode writes, page bytes and bus bytes
    for (int mw = 0; mw < 4; mw++) begin
      for (int k = 0; k < 8; k++) begin
        setMode(2'd1);
        setMode(2'(mw));
        cmdVecLoad = 1'b1; cmdVecData = 8'((k * 37) + 5); tick(); cmdVecLoad = 1'b0;
        doEnable();
        ackByte = 8'((k * 91) + 3);
        effMode = (mw == 3) ? 2'd1 : 2'(mw);
        expAddr = (effMode == 2'd0) ? 16'h0000 :
                  (effMode == 2'd1) ? 16'h0038 : {8'((k * 37) + 5), 8'((k * 91) + 3)};
        intN = 1'b0; endInstr();
        chk(svcValid == 1'b1, "R7 R13 int taken", svcValid, 1);
        chk(svcAddr == expAddr, "R8 R10 R11 target", svcAddr, expAddr);
        chk(svcFromBus == (effMode == 2'd0), "R9 R11 from-bus flag", svcFromBus, effMode == 2'd0);
        chk(svcByte == ackByte, "R9 byte", svcByte, ackByte);
        endInstr();
        chk(svcValid == 1'b0, "R7 iff cleared on take", svcValid, 0);
        intN = 1'b1;
      end
    end

    // R5: NMI ignores the enable state and is edge-only
    setMode(2'd1);
    nmiN = 1'b0; tick(); tick();
    endInstr();
    chk(svcValid && !svcFromBus && svcAddr == 16'h0066, "R5 nmi target", svcAddr, 16'h0066);
    endInstr();
    chk(svcValid == 1'b0, "R5 held low no retrigger", svcValid, 0);
    nmiN = 1'b1; tick();

    // R6 / R12: NMI wins over INT, saves iff, restore brings it back
    doEnable(); nmiEdge(); intN = 1'b0; endInstr();
    chk(svcValid && svcAddr == 16'h0066, "R6 nmi over int", svcAddr, 16'h0066);
    endInstr();
    chk(svcValid == 1'b0, "R12 nmi clears iff", svcValid, 0);
    cmdRestore = 1'b1; tick(); cmdRestore = 1'b0;
    endInstr();
    chk(svcValid && svcAddr == 16'h0038, "R12 restore from shadow", svcAddr, 16'h0038);
    intN = 1'b1;
    // R12: restore after an INT take gives a cleared shadow
    cmdRestore = 1'b1; tick(); cmdRestore = 1'b0;
    intN = 1'b0; endInstr(); intN = 1'b1;
    chk(svcValid == 1'b0, "R12 shadow cleared by int", svcValid, 0);
    // R12: disable beats enable
    cmdEnable = 1'b1; cmdDisable = 1'b1; tick(); cmdEnable = 1'b0; cmdDisable = 1'b0;
    intN = 1'b0; endInstr(); intN = 1'b1;
    chk(svcValid == 1'b0, "R12 disable wins", svcValid, 0);
    // R12: take overrides a same-cycle enable
    doEnable(); intN = 1'b0; cmdEnable = 1'b1; endInstr(); cmdEnable = 1'b0;
    chk(svcValid == 1'b1, "R12 take with enable", svcValid, 1);
    endInstr(); intN = 1'b1;
    chk(svcValid == 1'b0, "R12 take beats enable", svcValid, 0);

    // R2: request without boundary does nothing
    busReqN = 1'b0; tick(); tick(); tick();
    chk(busAckN == 1'b1 && floatEn == 1'b0, "R2 no boundary no grant", busAckN, 1);
    cycleEnd = 1'b1; tick(); cycleEnd = 1'b0;
    chk(busAckN == 1'b0 && floatEn == 1'b1, "R2 grant", {busAckN, floatEn}, 2'b01);
    // R4: NMI pending during grant not serviced
    nmiEdge(); endInstr();
    chk(svcValid == 1'b0, "R4 no service in grant", svcValid, 0);
    chk(busAckN == 1'b0, "R2 grant held", busAckN, 0);
    busReqN = 1'b1; tick();
    chk(busAckN == 1'b1 && floatEn == 1'b0, "R3 release", {busAckN, floatEn}, 2'b10);
    endInstr();
    chk(svcValid && svcAddr == 16'h0066, "R4 pending nmi after release", svcAddr, 16'h0066);

    // R4: grab in the same cycle as an instruction end blocks service
    doEnable(); intN = 1'b0; busReqN = 1'b0; cycleEnd = 1'b1; instrEnd = 1'b1;
    tick(); cycleEnd = 1'b0; instrEnd = 1'b0;
    chk(svcValid == 1'b0 && busAckN == 1'b0, "R4 grab blocks take", {svcValid, busAckN}, 2'b00);
    busReqN = 1'b1; tick();
    endInstr(); intN = 1'b1;
    chk(svcValid && svcAddr == 16'h0038, "R4 int after release", svcAddr, 16'h0038);

    tick();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

endmodule